// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers 64 level-sensitive interrupt sources into two 32-bit halves, low (sources 0-31) and high (sources 32-63). Each half has a cause register and an enable mask. A processor reaches them through a single-cycle register port. Four bits of the high half carry summary lines from an external general-purpose-pin unit. When one of those bits is pending and enabled, the block descends into that unit's masked cause word to name the interrupt.

The block drives one processor interrupt line and a 7-bit vector that names the interrupt to service. The vector holds a group code and the highest pending enabled bit within that group.

A select-cause register gives software one read that answers two questions: which half needs attention, and what that half's raw cause bits are. A flag bit inside the read word tells which half was chosen.

Top module: `cascade_intc`

## Requirements
- R1: After reset, the four cause and mask registers read as zero, `cpu_irq` is 0 and `irq_vec` is 0.
- R2: A cause bit is set on the clock edge at which its source input is high, and it stays set after the source drops. A write to the low cause register (offset 0x04) or the high cause register (offset 0x0C) ANDs the register with the written data, so writing zero clears it. A bit whose source is high at that edge stays set regardless of the write.
- R3: The low mask register is at offset 0x14 and the high mask register is at offset 0x1C. Both can be read and written. A mask bit of 1 enables its cause bit, and a mask bit of 0 blocks it from `cpu_irq` and `irq_vec`.
- R4: High cause bits 24 to 27 are set from `gpp_sum[0]` to `gpp_sum[3]` respectively, ORed with the matching bits of `src_hi`.
- R5: The select-cause register is at offset 0x24 and is read-only. It shows the low half when any enabled low bit is pending, or when no enabled bit is pending anywhere. Otherwise it shows the high half. Bit 30 of the read word is 1 when it shows the high half and 0 when it shows the low half. The other 31 bits are the raw cause bits of the half it shows.
- R6: `cpu_irq` is the OR of all enabled pending bits of both halves, as they stood before the clock edge, registered at that edge.
- R7: `irq_vec` is registered at the same edge as `cpu_irq`. Bits 6:5 hold the group code: 0 for low, 1 for high, 2 for the pin unit. Bits 4:0 hold the index of the highest-numbered enabled pending bit. The low half takes precedence over the high half. With nothing pending, the vector is 0.
- R8: When the low half has no enabled pending bit and any enabled high bit in 24 to 27 is pending, the vector uses group 2. Its index is then the highest set bit of `gpp_cause`, or 0 if `gpp_cause` is zero.
- R9: A read of any offset other than the five listed returns 0. A write to 0x24 or to an unlisted offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| src_lo | input | 32 | Level sources for the low half |
| src_hi | input | 32 | Level sources for the high half |
| gpp_sum | input | 4 | Summary lines from the pin unit, into high bits 24-27 |
| gpp_cause | input | 32 | Masked cause word of the pin unit |
| cpu_irq | output | 1 | Processor interrupt request |
| irq_vec | output | 7 | Group code (6:5) and bit index (4:0) |

## Verification
The bench targets these corner cases:

- **Clear write while the source is still high.** The bit must survive the write. A design that gave the write priority would drop a live interrupt.
- **Both halves pending at once.** The select-cause flag and the vector must both favour the low half. A swapped precedence would show the high word with bit 30 set.
- **Pin-unit cascade.** It is driven with a zero `gpp_cause` and with a nonzero one. A design that failed to descend would report group 1 with index 24 to 27 instead of group 2.
- **Masking, read-only offsets and unmapped offsets.** The bench blocks sources with a zero mask, writes to the read-only and unmapped offsets, and then reads the masks back. A mask decode error would leak through as a wrong `cpu_irq` or a corrupted mask.

// File: rtl/cascade_intc.sv
module cascade_intc #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_CAUSE_LO = 'h04,
  parameter logic [ADDR_W-1:0] A_CAUSE_HI = 'h0C,
  parameter logic [ADDR_W-1:0] A_MASK_LO  = 'h14,
  parameter logic [ADDR_W-1:0] A_MASK_HI  = 'h1C,
  parameter logic [ADDR_W-1:0] A_SELECT   = 'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [31:0]       src_lo,
  input  logic [31:0]       src_hi,
  input  logic [3:0]        gpp_sum,
  input  logic [31:0]       gpp_cause,
  output logic              cpu_irq,
  output logic [6:0]        irq_vec
);
  localparam int GPP_LSB = 24;
  localparam int GPP_N   = 4;
  localparam int FLAG    = 30;

  logic [31:0] cause_lo, cause_hi, mask_lo, mask_hi;
  logic [31:0] hi_src, en_lo, en_hi, sel_word;
  logic        any_lo, any_hi, gpp_hit, show_hi;
  logic [6:0]  vec_d;

  function automatic logic [4:0] top_bit(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) r = 5'(i);
    return r;
  endfunction

  assign hi_src  = src_hi | {{(32-GPP_LSB-GPP_N){1'b0}}, gpp_sum, {GPP_LSB{1'b0}}};
  assign en_lo   = cause_lo & mask_lo;
  assign en_hi   = cause_hi & mask_hi;
  assign any_lo  = |en_lo;
  assign any_hi  = |en_hi;
  assign gpp_hit = |en_hi[GPP_LSB+GPP_N-1:GPP_LSB];
  assign show_hi = !any_lo && any_hi;

  always_comb begin
    sel_word       = show_hi ? cause_hi : cause_lo;
    sel_word[FLAG] = show_hi;
  end

  always_comb begin
    if (any_lo)       vec_d = {2'd0, top_bit(en_lo)};
    else if (gpp_hit) vec_d = {2'd2, top_bit(gpp_cause)};
    else if (any_hi)  vec_d = {2'd1, top_bit(en_hi)};
    else              vec_d = '0;
  end

  always_comb begin
    case (addr)
      A_CAUSE_LO: rd_data = cause_lo;
      A_CAUSE_HI: rd_data = cause_hi;
      A_MASK_LO:  rd_data = mask_lo;
      A_MASK_HI:  rd_data = mask_hi;
      A_SELECT:   rd_data = sel_word;
      default:    rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_lo <= '0;
      cause_hi <= '0;
      mask_lo  <= '0;
      mask_hi  <= '0;
      cpu_irq  <= 1'b0;
      irq_vec  <= '0;
    end else begin
      cause_lo <= ((wr_en && addr == A_CAUSE_LO) ? (cause_lo & wr_data) : cause_lo) | src_lo;
      cause_hi <= ((wr_en && addr == A_CAUSE_HI) ? (cause_hi & wr_data) : cause_hi) | hi_src;
      if (wr_en && addr == A_MASK_LO) mask_lo <= wr_data;
      if (wr_en && addr == A_MASK_HI) mask_hi <= wr_data;
      cpu_irq  <= any_lo | any_hi;
      irq_vec  <= vec_d;
    end
  end
endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_CLR = 'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       src_lo,
  input logic [31:0]       cause_lo,
  input logic [31:0]       cause_hi,
  input logic [31:0]       mask_lo,
  input logic [31:0]       mask_hi,
  input logic              cpu_irq,
  input logic [6:0]        irq_vec
);
  AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_lo & $past(src_lo)) == $past(src_lo))); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR && wr_data == 32'd0) |=> (cause_lo == $past(src_lo))); // R2

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past((|(cause_lo & mask_lo)) || (|(cause_hi & mask_hi))))); // R6

  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> (irq_vec == 7'd0)); // R7

  AST_GROUP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec[6:5] != 2'd3); // R7
endmodule

bind cascade_intc cascade_intc_chk #(.ADDR_W(ADDR_W), .A_CLR(A_CAUSE_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .src_lo(src_lo), .cause_lo(cause_lo), .cause_hi(cause_hi),
  .mask_lo(mask_lo), .mask_hi(mask_hi), .cpu_irq(cpu_irq), .irq_vec(irq_vec)
);

// File: tb/cascade_intc_bench.sv
`timescale 1ns/1ps
module cascade_intc_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wr_data = 0, src_lo = 0, src_hi = 0, gpp_cause = 0;
  logic [3:0]  gpp_sum = 0;
  logic [31:0] rd_data;
  logic        cpu_irq;
  logic [6:0]  irq_vec;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_clo = 0, m_chi = 0, m_mlo = 0, m_mhi = 0;
  logic        e_irq = 0;
  logic [6:0]  e_vec = 0;

  always #2 clk = ~clk;

  cascade_intc u_cascade_intc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .src_lo(src_lo), .src_hi(src_hi), .gpp_sum(gpp_sum),
    .gpp_cause(gpp_cause), .cpu_irq(cpu_irq), .irq_vec(irq_vec)
  );

  function automatic logic [4:0] msb(input logic [31:0] v);
    logic [4:0] r = 0;
    for (int i = 0; i < 32; i++) if (v[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [6:0] exp_vec(input logic [31:0] clo, chi, mlo, mhi, gc);
    logic [31:0] a = clo & mlo, b = chi & mhi;
    if (a != 0) return {2'd0, msb(a)};
    if (b[27:24] != 0) return {2'd2, msb(gc)};
    if (b != 0) return {2'd1, msb(b)};
    return 7'd0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] w;
    logic hi;
    case (a)
      8'h04: return m_clo;
      8'h0C: return m_chi;
      8'h14: return m_mlo;
      8'h1C: return m_mhi;
      8'h24: begin
        hi = ((m_clo & m_mlo) == 0) && ((m_chi & m_mhi) != 0);
        w = hi ? m_chi : m_clo;
        w[30] = hi;
        return w;
      end
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    addr = a; wr_en = 0;
    #0.5;
    chk(tag, rd_data, exp_rd(a));
  endtask

  task automatic tick(input string tag);
    logic [31:0] hs, nlo, nhi, nmlo, nmhi;
    hs   = src_hi | {4'd0, gpp_sum, 24'd0};
    nlo  = ((wr_en && addr == 8'h04) ? (m_clo & wr_data) : m_clo) | src_lo;
    nhi  = ((wr_en && addr == 8'h0C) ? (m_chi & wr_data) : m_chi) | hs;
    nmlo = (wr_en && addr == 8'h14) ? wr_data : m_mlo;
    nmhi = (wr_en && addr == 8'h1C) ? wr_data : m_mhi;
    e_irq = ((m_clo & m_mlo) != 0) || ((m_chi & m_mhi) != 0);
    e_vec = exp_vec(m_clo, m_chi, m_mlo, m_mhi, gpp_cause);
    @(posedge clk);
    m_clo = nlo; m_chi = nhi; m_mlo = nmlo; m_mhi = nmhi;
    @(negedge clk);
    chk({tag, " irq R6"}, {31'd0, cpu_irq}, {31'd0, e_irq});
    chk({tag, " vec R7"}, {25'd0, irq_vec}, {25'd0, e_vec});
    wr_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    addr = a; wr_data = d; wr_en = 1;
    tick(tag);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] alist [6];
    alist = '{8'h04, 8'h0C, 8'h14, 8'h1C, 8'h24, 8'h30};
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk(8'h04, "R1 cause_lo"); chk("R1 cause_lo zero", rd_data, 0);
    rd_chk(8'h0C, "R1 cause_hi"); chk("R1 cause_hi zero", rd_data, 0);
    rd_chk(8'h14, "R1 mask_lo");  chk("R1 mask_lo zero", rd_data, 0);
    rd_chk(8'h1C, "R1 mask_hi");  chk("R1 mask_hi zero", rd_data, 0);
    chk("R1 irq", {31'd0, cpu_irq}, 0);
    chk("R1 vec", {25'd0, irq_vec}, 0);

    // R2 sticky, R3 blocked by zero mask
    src_lo = 32'h20; tick("R2 set");
    src_lo = 0; tick("R2 drop");
    rd_chk(8'h04, "R2 sticky"); chk("R2 sticky lit", rd_data, 32'h20);
    tick("R3 blocked");
    chk("R3 mask zero blocks", {31'd0, cpu_irq}, 0);
    wr(8'h14, 32'h20, "R3 mask wr");
    rd_chk(8'h14, "R3 mask rd"); chk("R3 mask lit", rd_data, 32'h20);
    tick("R3 enabled");
    chk("R3 irq on", {31'd0, cpu_irq}, 1);
    chk("R7 low vec", {25'd0, irq_vec}, 32'h05);

    // R2 clear while source held, then clear after release
    src_lo = 32'h20; wr(8'h04, 32'h0, "R2 clr held");
    rd_chk(8'h04, "R2 held"); chk("R2 survives clear", rd_data, 32'h20);
    src_lo = 0; wr(8'h04, 32'h0, "R2 clr");
    rd_chk(8'h04, "R2 cleared"); chk("R2 clear lit", rd_data, 0);

    // R4 pin summary into high bit 26
    gpp_sum = 4'b0100; tick("R4 set"); gpp_sum = 0;
    rd_chk(8'h0C, "R4 hi"); chk("R4 bit26", rd_data, 32'h0400_0000);

    // R8 cascade, R5 select shows high half
    gpp_cause = 32'h0000_1000;
    wr(8'h1C, 32'h0400_0000, "R8 mask hi");
    rd_chk(8'h24, "R5 sel hi"); chk("R5 sel hi lit", rd_data, 32'h4400_0000);
    tick("R8 cascade");
    chk("R8 gpp vec", {25'd0, irq_vec}, 32'h4C);
    gpp_cause = 0; tick("R8 zero cause"); tick("R8 zero cause2");
    chk("R8 gpp zero idx", {25'd0, irq_vec}, 32'h40);

    // R5 and R7 low precedence over high
    src_lo = 32'h20; tick("R5 both"); src_lo = 0;
    rd_chk(8'h24, "R5 sel lo"); chk("R5 sel lo lit", rd_data, 32'h20);
    tick("R7 both");
    chk("R7 low wins", {25'd0, irq_vec}, 32'h05);

    // R7 plain high group
    wr(8'h04, 0, "R7 clr lo"); wr(8'h0C, 0, "R7 clr hi");
    src_hi = 32'h8; wr(8'h1C, 32'h8, "R7 hi mask"); src_hi = 0;
    tick("R7 hi"); tick("R7 hi2");
    chk("R7 high vec", {25'd0, irq_vec}, 32'h23);

    // R9 read-only and unmapped offsets
    wr(8'h24, 32'hFFFF_FFFF, "R9 wr sel");
    wr(8'h30, 32'hFFFF_FFFF, "R9 wr unmapped");
    rd_chk(8'h14, "R9 mask_lo kept"); chk("R9 mask_lo lit", rd_data, 32'h20);
    rd_chk(8'h1C, "R9 mask_hi kept"); chk("R9 mask_hi lit", rd_data, 32'h8);
    rd_chk(8'h30, "R9 unmapped"); chk("R9 unmapped lit", rd_data, 0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int sel;
      sel = $urandom_range(0, 5);
      rd_chk(alist[sel], "R5 R9 rnd rd");
      src_lo    = $urandom & $urandom & $urandom & $urandom;
      src_hi    = $urandom & $urandom & $urandom & $urandom;
      gpp_sum   = 4'($urandom & $urandom);
      gpp_cause = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      addr      = alist[$urandom_range(0, 5)];
      wr_data   = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      wr_en     = ($urandom_range(0, 3) == 0);
      tick("R2 R8 rnd");
    end
    finish_run();
  end
endmodule